// File: doc/BRIEF.md
# I2C Slave With Byte Strobe Port

This block sits between an I2C bus and a simple passive target such as a memory, a display or a sensor. It answers to one 7-bit device address that is fixed when the block is built. Nothing needs to be configured: the slave responds to the bus as soon as reset is released.

The target side is a bare byte port. When the master writes, every received byte is placed on an 8-bit output bus and announced by a one-cycle write strobe. When the master reads, the block raises a one-cycle read strobe, takes the byte from the 8-bit input bus on the following clock, and shifts it out. Single-byte transfers, bursts of any length and repeated starts are recognized on their own.

SCL and SDA arrive on separate input pins. Each line is first synchronized to the system clock and then passes a spike filter before any edge is detected. SDA leaves on a separate output pin that only pulls the line low or releases it, so the block contains no tri-state logic. Everything runs on the rising edge of one clock with an active-high synchronous reset. With a fast enough system clock the block can keep up with bus rates of 100 kb/s, 400 kb/s and 3.4 Mb/s.

Top module: `i2c_strobe_slave`

## Requirements
- R1: After reset the slave releases SDA (sda_o = 1), both strobes are low, and it is ready for a START without any setup.
- R2: After a START, an address byte whose upper seven bits equal DEV_ADDR is acknowledged: SDA is held low while SCL is high during the ninth clock pulse.
- R3: An address byte whose upper seven bits differ from DEV_ADDR gets no acknowledge, and the slave leaves SDA released and both strobes low until the next START.
- R4: When bit 0 of the address byte is 0 (master write), each data byte is received MSB first, placed on tgt_wdata, announced by tgt_wr high for exactly one clock, and acknowledged in the ninth pulse.
- R5: A master write may carry any number of data bytes after the address. Each one gets its own write strobe and acknowledge, in bus order.
- R6: When bit 0 of the address byte is 1 (master read), tgt_rd is pulsed for one clock before each byte is sent. tgt_rdata is sampled on the clock after the strobe and shifted out MSB first. An acknowledge from the master (SDA low in the ninth pulse) causes a new strobe and the next byte.
- R7: A not-acknowledge from the master (SDA high in the ninth pulse) ends the read. SDA stays released and no further read strobe follows.
- R8: A START received in the middle of a transfer (repeated start) restarts address reception, and the new address byte is matched and acted on like the first one.
- R9: A STOP (SDA rising while SCL is high) returns the slave to idle. Clock pulses that arrive before the next START are neither acknowledged nor strobed.
- R10: A level on either bus line is accepted only after it has stayed stable for FILT_LEN system clocks. A shorter SCL pulse does not shift a bit.
- R11: tgt_wr and tgt_rd are never high in the same cycle, and the slave starts pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_o | output | 1 | Data line drive: 0 pulls low, 1 releases |
| tgt_rdata | input | 8 | Byte supplied by the target for a read |
| tgt_wdata | output | 8 | Byte delivered to the target on a write |
| tgt_wr | output | 1 | One-cycle strobe: tgt_wdata holds a new byte |
| tgt_rd | output | 1 | One-cycle strobe: target must present the next byte |

## Verification
The assertions assume a well-behaved master. It changes SDA only while SCL is low, except when it makes START and STOP conditions. Every SCL phase lasts much longer than the synchronizer and filter delay, so the filtered lines keep the ordering of the real bus, and the assertions on the filter assume FILT_LEN is at least 2. The bench master holds each SCL half period for 40 system clocks, combines its own SDA with the slave's drive as a wired AND, and injects spikes only two clocks wide, below the default filter length of four.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // not addressed, waiting for START
        ST_ADDR,   // shifting in the address byte
        ST_AWAIT,  // byte done, waiting for SCL low to drive ACK
        ST_AACK,   // driving ACK during ninth pulse
        ST_RX,     // receiving a write data byte
        ST_TX,     // shifting out a read data byte
        ST_MACK,   // sampling the master's acknowledge
        ST_TXW     // next read byte fetched, waiting for SCL low
    } i2cs_state_t;

    typedef struct packed {
        logic scl;
        logic sda;
    } i2cs_lines_t;

    localparam int unsigned BUS_LINES = 2;

    function automatic logic addr_hit(input logic [6:0] got, input logic [6:0] own);
        return got == own;
    endfunction

endpackage

// File: rtl/i2cs_filter.sv
module i2cs_filter #(
    parameter int unsigned LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int unsigned CW = $clog2(LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b11;
            cnt_q  <= '0;
            dout   <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], din};
            if (sync_q[1] == dout) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(LEN - 1)) begin
                cnt_q <= '0;
                dout  <= sync_q[1];
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R10: a new level is only taken after it was steady for several cycles
    a_r10_level_held: assert property (@(posedge clk) disable iff (rst)
        (dout != $past(dout)) |-> ($past(sync_q[1]) == dout && $past(sync_q[1], 2) == dout));

endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
    import i2cs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h5A
) (
    input  logic        clk,
    input  logic        rst,
    input  i2cs_lines_t bus,
    output logic        sda_o,
    input  logic [7:0]  tgt_rdata,
    output logic [7:0]  tgt_wdata,
    output logic        tgt_wr,
    output logic        tgt_rd
);
    i2cs_state_t st_q;
    i2cs_lines_t prev_q;
    logic [2:0]  cnt_q;
    logic [7:0]  sh_q;
    logic        rw_q;
    logic        ld_q;

    logic scl_rise, scl_fall, cond_start, cond_stop;

    always_comb begin
        scl_rise   = bus.scl & ~prev_q.scl;
        scl_fall   = ~bus.scl & prev_q.scl;
        cond_start = bus.scl & prev_q.scl & prev_q.sda & ~bus.sda;
        cond_stop  = bus.scl & prev_q.scl & ~prev_q.sda & bus.sda;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            prev_q    <= '{scl: 1'b1, sda: 1'b1};
            cnt_q     <= '0;
            sh_q      <= '0;
            rw_q      <= 1'b0;
            ld_q      <= 1'b0;
            sda_o     <= 1'b1;
            tgt_wdata <= '0;
            tgt_wr    <= 1'b0;
            tgt_rd    <= 1'b0;
        end else begin
            prev_q <= bus;
            tgt_wr <= 1'b0;
            tgt_rd <= 1'b0;
            ld_q   <= 1'b0;
            if (ld_q) sh_q <= tgt_rdata;

            if (cond_start) begin
                st_q  <= ST_ADDR;
                cnt_q <= '0;
                sda_o <= 1'b1;
            end else if (cond_stop) begin
                st_q  <= ST_IDLE;
                sda_o <= 1'b1;
            end else begin
                unique case (st_q)
                    ST_IDLE: ;
                    ST_ADDR: if (scl_rise) begin
                        sh_q  <= {sh_q[6:0], bus.sda};
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == 3'd7) begin
                            if (addr_hit(sh_q[6:0], DEV_ADDR)) begin
                                rw_q <= bus.sda;
                                st_q <= ST_AWAIT;
                            end else begin
                                st_q <= ST_IDLE;
                            end
                        end
                    end
                    ST_AWAIT: if (scl_fall) begin
                        sda_o <= 1'b0;
                        st_q  <= ST_AACK;
                    end
                    ST_AACK: begin
                        if (scl_rise && rw_q) begin
                            tgt_rd <= 1'b1;
                            ld_q   <= 1'b1;
                        end
                        if (scl_fall) begin
                            cnt_q <= '0;
                            if (rw_q) begin
                                sda_o <= sh_q[7];
                                st_q  <= ST_TX;
                            end else begin
                                sda_o <= 1'b1;
                                st_q  <= ST_RX;
                            end
                        end
                    end
                    ST_RX: if (scl_rise) begin
                        sh_q  <= {sh_q[6:0], bus.sda};
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == 3'd7) begin
                            tgt_wdata <= {sh_q[6:0], bus.sda};
                            tgt_wr    <= 1'b1;
                            rw_q      <= 1'b0;
                            st_q      <= ST_AWAIT;
                        end
                    end
                    ST_TX: if (scl_fall) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == 3'd7) begin
                            sda_o <= 1'b1;
                            st_q  <= ST_MACK;
                        end else begin
                            sh_q  <= {sh_q[6:0], 1'b0};
                            sda_o <= sh_q[6];
                        end
                    end
                    ST_MACK: if (scl_rise) begin
                        if (bus.sda) begin
                            st_q <= ST_IDLE;
                        end else begin
                            tgt_rd <= 1'b1;
                            ld_q   <= 1'b1;
                            st_q   <= ST_TXW;
                        end
                    end
                    ST_TXW: if (scl_fall) begin
                        sda_o <= sh_q[7];
                        cnt_q <= '0;
                        st_q  <= ST_TX;
                    end
                    default: st_q <= ST_IDLE;
                endcase
            end
        end
    end

    // R11: the two target strobes never coincide
    a_r11_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(tgt_wr && tgt_rd));
    // R4: write strobe lasts one cycle
    a_r4_wr_single: assert property (@(posedge clk) disable iff (rst)
        tgt_wr |=> !tgt_wr);
    // R6: read strobe lasts one cycle
    a_r6_rd_single: assert property (@(posedge clk) disable iff (rst)
        tgt_rd |=> !tgt_rd);
    // R11: SDA is only pulled low while the filtered clock is low
    a_r11_drive_scl_low: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_o) |-> !bus.scl);
    // R3: an idle slave never holds the data line
    a_r3_idle_released: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE) |-> sda_o);
    // R9: a stop always leads back to idle
    a_r9_stop_idle: assert property (@(posedge clk) disable iff (rst)
        cond_stop |=> (st_q == ST_IDLE));

endmodule

// File: rtl/i2c_strobe_slave.sv
module i2c_strobe_slave
    import i2cs_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR = 7'h5A,
    parameter int unsigned FILT_LEN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_o,
    input  logic [7:0] tgt_rdata,
    output logic [7:0] tgt_wdata,
    output logic       tgt_wr,
    output logic       tgt_rd
);
    logic [BUS_LINES-1:0] raw_lines;
    logic [BUS_LINES-1:0] clean_lines;
    i2cs_lines_t          bus;

    assign raw_lines = {scl_i, sda_i};

    for (genvar i = 0; i < BUS_LINES; i++) begin : g_filt
        i2cs_filter #(.LEN(FILT_LEN)) u_filt (
            .clk  (clk),
            .rst  (rst),
            .din  (raw_lines[i]),
            .dout (clean_lines[i])
        );
    end

    assign bus = i2cs_lines_t'(clean_lines);

    i2cs_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .bus       (bus),
        .sda_o     (sda_o),
        .tgt_rdata (tgt_rdata),
        .tgt_wdata (tgt_wdata),
        .tgt_wr    (tgt_wr),
        .tgt_rd    (tgt_rd)
    );

endmodule

// File: tb/i2c_strobe_slave_tb.sv
`timescale 1ns/1ps
module i2c_strobe_slave_tb;
    localparam logic [6:0] ADDR = 7'h5A;
    localparam int H = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1, m_sda = 1'b1, scl_gl = 1'b0;
    logic sda_o, tgt_wr, tgt_rd;
    logic [7:0] tgt_rdata = 8'h00, tgt_wdata;
    logic bus_sda, bus_scl;

    int checks = 0, errors = 0;
    int wr_cnt = 0, rd_cnt = 0, overlap = 0, long_pulse = 0;
    logic prev_wr = 1'b0, prev_rd = 1'b0;
    logic [7:0] wr_log [0:63];
    bit done = 0;

    always #5 clk = ~clk;

    assign bus_sda = m_sda & sda_o;
    assign bus_scl = m_scl | scl_gl;

    i2c_strobe_slave #(.DEV_ADDR(ADDR), .FILT_LEN(4)) u_dut (
        .clk(clk), .rst(rst), .scl_i(bus_scl), .sda_i(bus_sda), .sda_o(sda_o),
        .tgt_rdata(tgt_rdata), .tgt_wdata(tgt_wdata), .tgt_wr(tgt_wr), .tgt_rd(tgt_rd));

    function automatic logic [7:0] rpat(input int idx);
        return 8'hC3 ^ 8'(idx * 41);
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            if (tgt_wr && tgt_rd) overlap++;
            if ((tgt_wr && prev_wr) || (tgt_rd && prev_rd)) long_pulse++;
            if (tgt_wr) begin
                wr_log[wr_cnt % 64] = tgt_wdata;
                wr_cnt++;
            end
            if (tgt_rd) begin
                tgt_rdata = rpat(rd_cnt);
                rd_cnt++;
            end
            prev_wr = tgt_wr;
            prev_rd = tgt_rd;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        m_sda = 1'b1; wt(H/2);
        m_scl = 1'b1; wt(H);
        m_sda = 1'b0; wt(H);
        m_scl = 1'b0; wt(H/2);
    endtask

    task automatic bus_stop;
        m_scl = 1'b0; m_sda = 1'b0; wt(H);
        m_scl = 1'b1; wt(H);
        m_sda = 1'b1; wt(H);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_scl = 1'b0;
            m_sda = b[i];
            if (glitch && i == 3) begin
                wt(10); scl_gl = 1'b1; wt(2); scl_gl = 1'b0; wt(H - 12);
            end else begin
                wt(H);
            end
            m_scl = 1'b1; wt(H);
            m_scl = 1'b0;
        end
        m_sda = 1'b1; wt(H);
        m_scl = 1'b1; wt(H/2);
        ack = bus_sda; wt(H/2);
        m_scl = 1'b0;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            m_scl = 1'b0; wt(H);
            m_scl = 1'b1; wt(H/2);
            b[i] = bus_sda; wt(H/2);
        end
        m_scl = 1'b0;
        m_sda = mack; wt(H);
        m_scl = 1'b1; wt(H);
        m_scl = 1'b0; wt(H/4);
        m_sda = 1'b1;
    endtask

    task automatic t_reset;
        chk(sda_o == 1'b1, "R1 sda released", int'(sda_o), 1);
        chk(!tgt_wr && !tgt_rd, "R1 strobes low", int'({tgt_wr, tgt_rd}), 0);
    endtask

    task automatic t_write_single;
        logic a; int base = wr_cnt;
        bus_start;
        send_byte({ADDR, 1'b0}, 0, a);
        chk(a == 1'b0, "R2 address ack", int'(a), 0);
        send_byte(8'h3C, 0, a);
        chk(a == 1'b0, "R4 data ack", int'(a), 0);
        bus_stop;
        chk(wr_cnt == base + 1, "R4 one strobe", wr_cnt - base, 1);
        chk(wr_log[base % 64] == 8'h3C, "R4 byte value", int'(wr_log[base % 64]), 8'h3C);
    endtask

    task automatic t_burst;
        logic a; int base = wr_cnt; logic [7:0] d [3] = '{8'h11, 8'hE2, 8'h73};
        int acks = 0;
        bus_start;
        send_byte({ADDR, 1'b0}, 0, a);
        for (int k = 0; k < 3; k++) begin
            send_byte(d[k], 0, a);
            if (a == 1'b0) acks++;
        end
        bus_stop;
        chk(acks == 3, "R5 burst acks", acks, 3);
        chk(wr_cnt == base + 3, "R5 burst strobes", wr_cnt - base, 3);
        for (int k = 0; k < 3; k++)
            chk(wr_log[(base + k) % 64] == d[k], "R5 burst order", int'(wr_log[(base + k) % 64]), int'(d[k]));
    endtask

    task automatic t_mismatch;
        logic a1, a2; int wb = wr_cnt, rb = rd_cnt;
        bus_start;
        send_byte({7'h3C, 1'b0}, 0, a1);
        send_byte(8'h55, 0, a2);
        bus_stop;
        chk(a1 == 1'b1 && a2 == 1'b1, "R3 no ack", int'({a1, a2}), 3);
        chk(wr_cnt == wb && rd_cnt == rb, "R3 no strobes", (wr_cnt - wb) + (rd_cnt - rb), 0);
    endtask

    task automatic t_read;
        logic a; logic [7:0] b0, b1; int rb = rd_cnt;
        bus_start;
        send_byte({ADDR, 1'b1}, 0, a);
        chk(a == 1'b0, "R2 read address ack", int'(a), 0);
        recv_byte(1'b0, b0);
        recv_byte(1'b1, b1);
        chk(b0 == rpat(rb), "R6 first byte", int'(b0), int'(rpat(rb)));
        chk(b1 == rpat(rb + 1), "R6 second byte", int'(b1), int'(rpat(rb + 1)));
        wt(H);
        chk(bus_sda == 1'b1, "R7 sda released after nack", int'(bus_sda), 1);
        bus_stop;
        chk(rd_cnt == rb + 2, "R7 no strobe after nack", rd_cnt - rb, 2);
    endtask

    task automatic t_rstart;
        logic a; logic [7:0] b; int wb = wr_cnt, rb = rd_cnt;
        bus_start;
        send_byte({ADDR, 1'b0}, 0, a);
        send_byte(8'h77, 0, a);
        bus_start;
        send_byte({ADDR, 1'b1}, 0, a);
        chk(a == 1'b0, "R8 ack after repeated start", int'(a), 0);
        recv_byte(1'b1, b);
        bus_stop;
        chk(wr_cnt == wb + 1 && wr_log[wb % 64] == 8'h77, "R8 write before restart", int'(wr_log[wb % 64]), 8'h77);
        chk(b == rpat(rb), "R8 read after restart", int'(b), int'(rpat(rb)));
    endtask

    task automatic t_stop_idle;
        logic a; int wb;
        bus_start;
        send_byte({ADDR, 1'b0}, 0, a);
        send_byte(8'h10, 0, a);
        bus_stop;
        wb = wr_cnt;
        send_byte(8'h99, 0, a);
        chk(a == 1'b1, "R9 no ack after stop", int'(a), 1);
        send_byte({ADDR, 1'b0}, 0, a);
        chk(a == 1'b1, "R9 address ignored without start", int'(a), 1);
        bus_stop;
        chk(wr_cnt == wb, "R9 no strobe after stop", wr_cnt - wb, 0);
    endtask

    task automatic t_glitch;
        logic a; int wb = wr_cnt;
        bus_start;
        send_byte({ADDR, 1'b0}, 0, a);
        send_byte(8'hA5, 1, a);
        chk(a == 1'b0, "R10 ack with spike", int'(a), 0);
        bus_stop;
        chk(wr_cnt == wb + 1 && wr_log[wb % 64] == 8'hA5, "R10 spike ignored", int'(wr_log[wb % 64]), 8'hA5);
    endtask

    initial begin
        wt(5);
        rst = 1'b0;
        wt(4);
        t_reset;
        t_write_single;
        t_burst;
        t_mismatch;
        t_read;
        t_rstart;
        t_stop_idle;
        t_glitch;
        chk(overlap == 0, "R11 strobes exclusive", overlap, 0);
        chk(long_pulse == 0, "R11 strobes one cycle", long_pulse, 0);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule